// File: doc/BRIEF.md
# Hardware register read access controller

This block serves the user-mode instruction that reads a small set of hardware registers. A request carries a 5-bit register number and a 3-bit select field. The block checks whether the read is permitted, then returns the chosen value one clock later. If the read is not permitted, it raises a reserved-instruction trap instead. A read is permitted when the core holds coprocessor-0 privilege, or when the matching bit of a per-register enable mask is set.

The block also holds that enable mask. Software writes the mask, but each bit takes the write only if the current configuration allows it. The inputs that decide this are the architecture release (legacy or newer), whether performance counters exist, and whether the user-local register exists. The values the block returns come from other units and arrive on plain input ports: the CPU number, the cache-line step, the cycle counter and its resolution, performance control 0, the no-extended-paired-load flag and the user-local register.

Top module: `hwreg_read_ctrl`

## Requirements
- R1: After reset, `en_mask` is all zeros and neither `rd_valid` nor `rd_trap` is high.
- R2: Enable-mask bits 3:0 take the value written on `wr_data[3:0]` in every configuration. The new mask is visible on `en_mask` one cycle after `wr_en`.
- R3: Enable-mask bit 4 is written only when `perf_present` and `release6` are both 1. In any other case a write clears bit 4.
- R4: Enable-mask bit 5 is written only when `release6` is 1, and bit 29 only when `ulr_present` is 1. Every other mask bit always reads 0, whatever is written.
- R5: A request permitted by neither `priv_cp0` nor `en_mask[rd_num]` gives `rd_trap`=1 with `rd_data`=0 in the next cycle. A read in the same cycle as a mask write is checked against the old mask.
- R6: Register 0 returns `cpu_num` zero-extended. Registers 1, 2 and 3 return `synci_step`, `cycle_count` and `cycle_res`.
- R7: Register 4 with select 0 returns `perf_ctl0`. Register 4 with any non-zero select traps, even with privilege.
- R8: Register 5 returns `xnp_flag` in bit 0, with all other bits 0.
- R9: With `release6`=0, registers 4 and 5 trap whatever the privilege and mask.
- R10: Register 29 returns `user_local` when `ulr_present`=1 and traps otherwise. Register numbers 6 to 28, 30 and 31 always trap.
- R11: `rd_valid` and `rd_trap` are never high together. Each is high only in the cycle after a request (`rd_req`=1), and exactly one of them is high then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| release6 | input | 1 | 1 = newer-release mode |
| perf_present | input | 1 | Performance counters implemented |
| ulr_present | input | 1 | User-local register implemented |
| priv_cp0 | input | 1 | Core holds coprocessor-0 privilege |
| wr_en | input | 1 | Write the enable mask |
| wr_data | input | 32 | Enable-mask write value |
| en_mask | output | 32 | Current enable mask |
| rd_req | input | 1 | Read request |
| rd_num | input | 5 | Register number |
| rd_sel | input | 3 | Select field |
| cpu_num | input | 10 | CPU number (low bits of exception base) |
| synci_step | input | XLEN | Cache-line step |
| cycle_count | input | XLEN | Cycle counter |
| cycle_res | input | XLEN | Cycle counter resolution |
| perf_ctl0 | input | XLEN | Performance control 0 |
| xnp_flag | input | 1 | No-extended-paired-load flag (config 5 bit 13) |
| user_local | input | XLEN | User-local register |
| rd_valid | output | 1 | Read succeeded, `rd_data` valid |
| rd_trap | output | 1 | Reserved-instruction trap |
| rd_data | output | XLEN | Read result, 0 on trap |

## Verification
The bench targets the mask write under each mix of the release and feature inputs. A wrong write mask would let bit 4, bit 5 or bit 29 stick, or would drop a low bit. It aims register 4 reads at non-zero selects while privileged; a design that checked only the permission would return the counter control instead of trapping. It issues legacy-mode reads of registers 4 and 5, reads of unimplemented numbers, and reads of register 29 without the user-local feature, each of which must trap. It also reads in the same cycle as a mask write, where a design that forwarded the new mask would grant or refuse the read wrongly.

// File: rtl/hwreg_read_ctrl.sv
module hwreg_read_ctrl #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            release6,
  input  logic            perf_present,
  input  logic            ulr_present,
  input  logic            priv_cp0,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     en_mask,
  input  logic            rd_req,
  input  logic [4:0]      rd_num,
  input  logic [2:0]      rd_sel,
  input  logic [9:0]      cpu_num,
  input  logic [XLEN-1:0] synci_step,
  input  logic [XLEN-1:0] cycle_count,
  input  logic [XLEN-1:0] cycle_res,
  input  logic [XLEN-1:0] perf_ctl0,
  input  logic            xnp_flag,
  input  logic [XLEN-1:0] user_local,
  output logic            rd_valid,
  output logic            rd_trap,
  output logic [XLEN-1:0] rd_data
);

  logic [31:0]     wmask;
  logic            exists;
  logic            allowed;
  logic            bad_sel;
  logic            trap_c;
  logic [XLEN-1:0] value;

  assign wmask = {2'b0, ulr_present, 23'b0, release6, perf_present & release6, 4'hF};

  always_ff @(posedge clk) begin
    if (!rst_n)     en_mask <= '0;
    else if (wr_en) en_mask <= wr_data & wmask;
  end

  always_comb begin
    exists = 1'b0;
    value  = '0;
    case (rd_num)
      5'd0:  begin exists = 1'b1; value = XLEN'(cpu_num); end
      5'd1:  begin exists = 1'b1; value = synci_step; end
      5'd2:  begin exists = 1'b1; value = cycle_count; end
      5'd3:  begin exists = 1'b1; value = cycle_res; end
      5'd4:  begin exists = release6; value = perf_ctl0; end
      5'd5:  begin exists = release6; value = XLEN'(xnp_flag); end
      5'd29: begin exists = ulr_present; value = user_local; end
      default: ;
    endcase
  end

  assign allowed = priv_cp0 | en_mask[rd_num];
  assign bad_sel = (rd_num == 5'd4) && (rd_sel != 3'd0);
  assign trap_c  = !exists || !allowed || bad_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_trap  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req && !trap_c;
      rd_trap  <= rd_req && trap_c;
      rd_data  <= (rd_req && !trap_c) ? value : '0;
    end
  end

  // R2
  low_bits_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_mask[3:0] == $past(wr_data[3:0]));

  // R3
  bit4_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(perf_present && release6)) |=> !en_mask[4]);

  // R4
  bit5_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !release6) |=> !en_mask[5]);

  // R7
  sel_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_num == 5'd4 && rd_sel != 3'd0) |=> rd_trap);

  // R9
  legacy_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !release6 && (rd_num == 5'd4 || rd_num == 5'd5)) |=> rd_trap);

  // R11
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $countones({rd_valid, rd_trap}) == 1);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid && !rd_trap);

endmodule

// File: tb/hwreg_read_ctrl_tb.sv
module hwreg_read_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic release6 = 0, perf_present = 0, ulr_present = 0, priv_cp0 = 0;
  logic wr_en = 0, rd_req = 0, xnp_flag = 0;
  logic [31:0] wr_data = '0, en_mask;
  logic [4:0] rd_num = '0;
  logic [2:0] rd_sel = '0;
  logic [9:0] cpu_num = '0;
  logic [XLEN-1:0] synci_step = '0, cycle_count = '0, cycle_res = '0;
  logic [XLEN-1:0] perf_ctl0 = '0, user_local = '0, rd_data;
  logic rd_valid, rd_trap;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;
  logic [31:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwreg_read_ctrl #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .release6(release6), .perf_present(perf_present),
    .ulr_present(ulr_present), .priv_cp0(priv_cp0), .wr_en(wr_en), .wr_data(wr_data),
    .en_mask(en_mask), .rd_req(rd_req), .rd_num(rd_num), .rd_sel(rd_sel),
    .cpu_num(cpu_num), .synci_step(synci_step), .cycle_count(cycle_count),
    .cycle_res(cycle_res), .perf_ctl0(perf_ctl0), .xnp_flag(xnp_flag),
    .user_local(user_local), .rd_valid(rd_valid), .rd_trap(rd_trap), .rd_data(rd_data));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask_f();
    return {2'b0, ulr_present, 23'b0, release6, perf_present & release6, 4'hF};
  endfunction

  function automatic bit exists_f();
    case (rd_num)
      5'd0, 5'd1, 5'd2, 5'd3: return 1;
      5'd4, 5'd5: return release6;
      5'd29: return ulr_present;
      default: return 0;
    endcase
  endfunction

  function automatic bit trap_f();
    return !exists_f() || !(priv_cp0 || m_mask[rd_num]) || (rd_num == 4 && rd_sel != 0);
  endfunction

  function automatic logic [XLEN-1:0] value_f();
    case (rd_num)
      5'd0: return XLEN'(cpu_num);
      5'd1: return synci_step;
      5'd2: return cycle_count;
      5'd3: return cycle_res;
      5'd4: return perf_ctl0;
      5'd5: return XLEN'(xnp_flag);
      default: return user_local;
    endcase
  endfunction

  function automatic string tag_f();
    if (rd_num == 4 && rd_sel != 0) return "R7";
    if (!release6 && (rd_num == 4 || rd_num == 5)) return "R9";
    if (!exists_f()) return "R10";
    if (!(priv_cp0 || m_mask[rd_num])) return "R5";
    case (rd_num)
      5'd4: return "R7";
      5'd5: return "R8";
      5'd29: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic step();
    bit e_trap;
    logic [XLEN-1:0] e_val;
    string t;
    logic [31:0] nm;
    e_trap = trap_f();
    e_val = e_trap ? '0 : value_f();
    t = tag_f();
    nm = wr_en ? (wr_data & wmask_f()) : m_mask;
    @(negedge clk);
    if (rd_req) begin
      check({t, " trap"}, rd_trap, e_trap);
      check({t, " valid"}, rd_valid, !e_trap);
      check({t, " data"}, rd_data, e_val);
    end else begin
      check("R11 idle", {rd_valid, rd_trap}, 2'b00);
    end
    if (wr_en) begin
      check("R2 low", en_mask[3:0], wr_data[3:0]);
      check("R3 bit4", en_mask[4], nm[4]);
      check("R4 rest", {en_mask[31:5]}, {nm[31:5]});
    end
    m_mask = nm;
  endtask

  task automatic rand_vals();
    cpu_num = 10'($urandom); synci_step = $urandom; cycle_count = $urandom;
    cycle_res = $urandom; perf_ctl0 = $urandom; user_local = $urandom;
    xnp_flag = 1'($urandom);
  endtask

  task automatic do_read(logic [4:0] n, logic [2:0] s, logic p);
    rand_vals();
    wr_en = 0; rd_req = 1; rd_num = n; rd_sel = s; priv_cp0 = p;
    step();
    rd_req = 0;
  endtask

  task automatic do_write(logic [31:0] d);
    rd_req = 0; wr_en = 1; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 mask", en_mask, 0);
    check("R1 resp", {rd_valid, rd_trap}, 2'b00);
    rst_n = 1;

    // R3 R4: writes in legacy mode without features
    release6 = 0; perf_present = 1; ulr_present = 0;
    do_write(32'hFFFF_FFFF);
    // R9: legacy traps for 4 and 5 even privileged
    do_read(5'd4, 3'd0, 1);
    do_read(5'd5, 3'd0, 1);
    // R10
    do_read(5'd29, 3'd0, 1);
    do_read(5'd17, 3'd0, 1);
    // R6 user access via mask
    do_read(5'd2, 3'd0, 0);
    // newer release, all features
    release6 = 1; ulr_present = 1;
    do_write(32'hFFFF_FFFF);
    do_read(5'd4, 3'd0, 0);
    do_read(5'd4, 3'd5, 1);   // R7 non-zero select traps with privilege
    do_read(5'd5, 3'd0, 0);   // R8
    do_read(5'd29, 3'd0, 0);  // R10
    do_read(5'd31, 3'd0, 1);  // R10
    perf_present = 0;
    do_write(32'h0000_0030);  // R3 bit4 cleared
    do_write(32'h0000_0000);
    do_read(5'd0, 3'd0, 0);   // R5 denied
    // R5: read together with write uses old mask
    rand_vals();
    wr_en = 1; wr_data = 32'h1; rd_req = 1; rd_num = 0; rd_sel = 0; priv_cp0 = 0;
    step();
    wr_en = 0; rd_req = 0;
    do_read(5'd0, 3'd0, 0);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        release6 = 1'($urandom); perf_present = 1'($urandom); ulr_present = 1'($urandom);
      end
      rand_vals();
      wr_en = ($urandom_range(0, 3) == 0);
      wr_data = $urandom;
      rd_req = ($urandom_range(0, 4) != 0);
      case ($urandom_range(0, 3))
        0: rd_num = 5'($urandom);
        default: rd_num = 5'($urandom_range(0, 5));
      endcase
      if ($urandom_range(0, 5) == 0) rd_num = 5'd29;
      rd_sel = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
      priv_cp0 = ($urandom_range(0, 3) == 0);
      step();
    end
    wr_en = 0; rd_req = 0;
    finish_run();
  end
endmodule